// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of page table entries so that a virtual page number can be turned into a physical frame number without a page walk. Every slot is compared in parallel against the presented virtual page number. Each slot also carries an address-space identifier, so the mappings of several processes can sit side by side. A global flag lets a shared mapping match under any identifier. The page offset does not pass through the block, because virtual and physical pages have the same size.

A requester presents a virtual page number, an address-space identifier and an access type. In the following cycle the block reports one of three results: a usable hit with its frame number, a permission fault, or a miss. On a miss the requester walks the page table outside the block and writes the result back through the refill port. The refill port places the new entry in an empty slot, or in a pseudo-random slot when all slots are full. The invalidate port either empties the whole structure or drops the private entries of one address space.

Top module: `asid_tlb`

## Requirements
- R1: After a synchronous active-low reset every slot is empty, every result output is 0, and any lookup that follows reports a miss.
- R2: A lookup presented with `lk_valid` high at a clock edge has its result on the registered outputs after that edge, with `rs_valid` high. While `lk_valid` is low at an edge, `rs_valid`, `rs_hit`, `rs_miss`, `rs_fault` and `rs_pfn` are all 0 after it.
- R3: A slot matches a lookup when it is valid, its stored page number equals `lk_vpn`, and either its global flag is set or its identifier equals `lk_asid`. A permitted match reports `rs_hit`=1 with that slot's frame number on `rs_pfn`.
- R4: The permission bits are bit0 read, bit1 write and bit2 execute. `lk_acc` 00 needs read, 01 needs write, 10 needs execute, and 11 (read-modify-write) needs both read and write. A match that lacks a needed bit reports `rs_fault`=1, `rs_hit`=0 and `rs_pfn`=0. When `rs_valid` is high, exactly one of hit, miss and fault is set.
- R5: A lookup that matches no slot reports `rs_miss`=1 and `rs_pfn`=0.
- R6: An accepted refill that matches no slot goes into the lowest-numbered empty slot whenever one exists.
- R7: An accepted refill that matches no slot and finds no empty slot goes into the slot numbered by the low 4 bits of a 16-bit shift register. The register is seeded with 0xACE1 while reset is active and shifts on every clock edge outside reset. Each shift moves the register left by one bit and brings in bit15 xor bit13 xor bit12 xor bit10 at bit0. The refill uses the register value from before the edge.
- R8: A refill conflicts with a slot that is valid, holds the same page number, and has an equal identifier or a global flag on either side. On a conflict, the new entry replaces the lowest-numbered conflicting slot and every other conflicting slot is emptied, so a lookup never matches more than one slot.
- R9: `inv_all` empties every slot, global ones included, at that edge.
- R10: `inv_asid_en` empties, at that edge, every valid slot whose global flag is clear and whose identifier equals `inv_asid`. All other slots are kept.
- R11: A refill in the same cycle as `inv_all` or `inv_asid_en` is dropped. A lookup in the same cycle as a refill or an invalidate sees the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Address-space identifier of the lookup |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 read-modify-write |
| rf_valid | input | 1 | Refill request this cycle |
| rf_vpn | input | 20 | Virtual page number of the new entry |
| rf_asid | input | 8 | Address-space identifier of the new entry |
| rf_pfn | input | 20 | Physical frame number of the new entry |
| rf_perm | input | 3 | Permissions of the new entry: bit0 read, bit1 write, bit2 execute |
| rf_global | input | 1 | New entry matches under any identifier |
| inv_all | input | 1 | Empty every slot |
| inv_asid_en | input | 1 | Empty the non-global slots of one identifier |
| inv_asid | input | 8 | Identifier to drop when `inv_asid_en` is high |
| rs_valid | output | 1 | A lookup result is present |
| rs_hit | output | 1 | Translation found and access permitted |
| rs_miss | output | 1 | No slot matched |
| rs_fault | output | 1 | Slot matched but access not permitted |
| rs_pfn | output | 20 | Frame number on a hit, otherwise 0 |

## Verification
Lookup results are due exactly one edge after the request. Refill and invalidate effects show on a lookup whose request is sampled at the edge after the write. The reference model therefore updates at the same posedge as the design: it first computes the expected result from its pre-edge contents, and only then applies that edge's flush or refill. Both sides are compared at the following falling edge. Because the replacement rule is stated as an exact shift-register sequence, the model steps its own register on every edge after reset, and it predicts the evicted slot even under long random refill streams.

// File: rtl/tlb_pkg.sv
// Package: shared access-type encoding, permission bit positions and the
// replacement shift-register constants for the translation cache.
// Assumes: permissions are always three bits (read, write, execute).
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RMW   = 2'b11
    } acc_t;

    localparam int PERM_BITS = 3;
    localparam int PB_READ   = 0;
    localparam int PB_WRITE  = 1;
    localparam int PB_EXEC   = 2;

    localparam int              RAND_W    = 16;
    localparam logic [RAND_W-1:0] RAND_SEED = 16'hACE1;

    // Permission bits that an access type requires.
    function automatic logic [PERM_BITS-1:0] need_mask(acc_t a);
        logic [PERM_BITS-1:0] m;
        m = '0;
        case (a)
            ACC_READ:  m[PB_READ]  = 1'b1;
            ACC_WRITE: m[PB_WRITE] = 1'b1;
            ACC_EXEC:  m[PB_EXEC]  = 1'b1;
            default: begin
                m[PB_READ]  = 1'b1;
                m[PB_WRITE] = 1'b1;
            end
        endcase
        return m;
    endfunction

    // One step of the replacement shift register.
    function automatic logic [RAND_W-1:0] rand_step(logic [RAND_W-1:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[RAND_W-2:0], fb};
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
// Module: tlb_entry_array
// Holds the translation slots and compares every slot in parallel against
// the lookup key and the refill key. Applies flushes and writes.
// Assumes: the caller never raises wr_en in a cycle with a flush; only the
// valid bits are reset, the data fields are read only while valid.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic [ASID_W-1:0]          lk_asid,
    input  logic [VPN_W-1:0]           rf_vpn,
    input  logic [ASID_W-1:0]          rf_asid,
    input  logic [PFN_W-1:0]           rf_pfn,
    input  logic [PERM_BITS-1:0]       rf_perm,
    input  logic                       rf_global,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       flush_all,
    input  logic                       flush_asid_en,
    input  logic [ASID_W-1:0]          flush_asid,
    output logic [ENTRIES-1:0]         valid_o,
    output logic [ENTRIES-1:0]         lk_match_o,
    output logic [ENTRIES-1:0]         rf_match_o,
    output logic [ENTRIES*PFN_W-1:0]   pfn_flat_o,
    output logic [ENTRIES*PERM_BITS-1:0] perm_flat_o
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic                 v_q;
        logic                 g_q;
        logic [ASID_W-1:0]    asid_q;
        logic [VPN_W-1:0]     vpn_q;
        logic [PFN_W-1:0]     pfn_q;
        logic [PERM_BITS-1:0] perm_q;
        logic                 sel;

        assign sel = wr_en && (wr_idx == IDX_W'(i));

        // Valid bit: reset, flushes, write and conflict removal.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (flush_all) begin
                v_q <= 1'b0;
            end else if (flush_asid_en && !g_q && (asid_q == flush_asid)) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end else if (wr_en && rf_match_o[i]) begin
                v_q <= 1'b0;
            end
        end

        // Data fields: loaded only when this slot is written.
        always_ff @(posedge clk) begin
            if (sel) begin
                g_q    <= rf_global;
                asid_q <= rf_asid;
                vpn_q  <= rf_vpn;
                pfn_q  <= rf_pfn;
                perm_q <= rf_perm;
            end
        end

        // Parallel compare against the lookup key.
        assign lk_match_o[i] = v_q && (vpn_q == lk_vpn) &&
                               (g_q || (asid_q == lk_asid));
        // Parallel compare against the refill key (conflict detection).
        assign rf_match_o[i] = v_q && (vpn_q == rf_vpn) &&
                               (g_q || rf_global || (asid_q == rf_asid));

        assign valid_o[i] = v_q;
        assign pfn_flat_o[i*PFN_W +: PFN_W]            = pfn_q;
        assign perm_flat_o[i*PERM_BITS +: PERM_BITS]   = perm_q;
    end

endmodule

// File: rtl/tlb_victim_sel.sv
// Module: tlb_victim_sel
// Picks the slot a refill writes: the lowest conflicting slot first, then
// the lowest empty slot, otherwise a pseudo-random slot taken from a
// free-running shift register.
// Assumes: ENTRIES is a power of two between 2 and 65536.
module tlb_victim_sel
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [ENTRIES-1:0] conflict_i,
    output logic [IDX_W-1:0]   idx_o
);

    logic [RAND_W-1:0] rand_q;
    logic [IDX_W-1:0]  first_conf;
    logic [IDX_W-1:0]  first_free;
    logic              any_conf;
    logic              any_free;

    // Free-running replacement register, advancing on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rand_q <= RAND_SEED;
        end else begin
            rand_q <= rand_step(rand_q);
        end
    end

    // Lowest-numbered conflicting slot.
    always_comb begin
        any_conf   = 1'b0;
        first_conf = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (conflict_i[i]) begin
                any_conf   = 1'b1;
                first_conf = IDX_W'(i);
            end
        end
    end

    // Lowest-numbered empty slot.
    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                any_free   = 1'b1;
                first_free = IDX_W'(i);
            end
        end
    end

    // Final choice in priority order.
    always_comb begin
        if (any_conf) begin
            idx_o = first_conf;
        end else if (any_free) begin
            idx_o = first_free;
        end else begin
            idx_o = rand_q[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/tlb_result_mux.sv
// Module: tlb_result_mux
// Folds the one-hot lookup match vector into a single frame number and
// permission field with an AND-OR tree.
// Assumes: at most one match bit is set.
module tlb_result_mux
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20
) (
    input  logic [ENTRIES-1:0]           match_i,
    input  logic [ENTRIES*PFN_W-1:0]     pfn_flat_i,
    input  logic [ENTRIES*PERM_BITS-1:0] perm_flat_i,
    output logic                         any_o,
    output logic [PFN_W-1:0]             pfn_o,
    output logic [PERM_BITS-1:0]         perm_o
);

    // AND-OR selection of the matching slot's fields.
    always_comb begin
        pfn_o  = '0;
        perm_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_i[i]) begin
                pfn_o  = pfn_o  | pfn_flat_i[i*PFN_W +: PFN_W];
                perm_o = perm_o | perm_flat_i[i*PERM_BITS +: PERM_BITS];
            end
        end
    end

    assign any_o = |match_i;

endmodule

// File: rtl/asid_tlb.sv
// Module: asid_tlb
// Fully associative, identifier-tagged translation cache. A lookup returns
// hit/miss/fault and the frame number on the registered outputs one edge
// later. Refills land in the conflicting, empty or pseudo-random slot;
// invalidates drop every slot or the private slots of one identifier.
// Assumes: synchronous active-low reset; flushes win over a refill.
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [ASID_W-1:0]    lk_asid,
    input  logic [1:0]           lk_acc,
    input  logic                 rf_valid,
    input  logic [VPN_W-1:0]     rf_vpn,
    input  logic [ASID_W-1:0]    rf_asid,
    input  logic [PFN_W-1:0]     rf_pfn,
    input  logic [PERM_BITS-1:0] rf_perm,
    input  logic                 rf_global,
    input  logic                 inv_all,
    input  logic                 inv_asid_en,
    input  logic [ASID_W-1:0]    inv_asid,
    output logic                 rs_valid,
    output logic                 rs_hit,
    output logic                 rs_miss,
    output logic                 rs_fault,
    output logic [PFN_W-1:0]     rs_pfn
);

    logic [ENTRIES-1:0]           entry_valid;
    logic [ENTRIES-1:0]           lk_match;
    logic [ENTRIES-1:0]           rf_match;
    logic [ENTRIES*PFN_W-1:0]     pfn_flat;
    logic [ENTRIES*PERM_BITS-1:0] perm_flat;
    logic [IDX_W-1:0]             victim;
    logic                         wr_en;
    logic                         sel_any;
    logic [PFN_W-1:0]             sel_pfn;
    logic [PERM_BITS-1:0]         sel_perm;
    logic [PERM_BITS-1:0]         need;
    logic                         allowed;

    // A refill is accepted only when no invalidate is active.
    assign wr_en = rf_valid && !inv_all && !inv_asid_en;

    tlb_entry_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
    ) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_vpn       (lk_vpn),
        .lk_asid      (lk_asid),
        .rf_vpn       (rf_vpn),
        .rf_asid      (rf_asid),
        .rf_pfn       (rf_pfn),
        .rf_perm      (rf_perm),
        .rf_global    (rf_global),
        .wr_en        (wr_en),
        .wr_idx       (victim),
        .flush_all    (inv_all),
        .flush_asid_en(inv_asid_en),
        .flush_asid   (inv_asid),
        .valid_o      (entry_valid),
        .lk_match_o   (lk_match),
        .rf_match_o   (rf_match),
        .pfn_flat_o   (pfn_flat),
        .perm_flat_o  (perm_flat)
    );

    tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (entry_valid),
        .conflict_i(rf_match),
        .idx_o     (victim)
    );

    tlb_result_mux #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_mux (
        .match_i    (lk_match),
        .pfn_flat_i (pfn_flat),
        .perm_flat_i(perm_flat),
        .any_o      (sel_any),
        .pfn_o      (sel_pfn),
        .perm_o     (sel_perm)
    );

    // Permission test of the matched slot against the access type.
    assign need    = need_mask(acc_t'(lk_acc));
    assign allowed = ((sel_perm & need) == need);

    // Registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_miss  <= 1'b0;
            rs_fault <= 1'b0;
            rs_pfn   <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid && sel_any && allowed;
            rs_fault <= lk_valid && sel_any && !allowed;
            rs_miss  <= lk_valid && !sel_any;
            rs_pfn   <= (lk_valid && sel_any && allowed) ? sel_pfn : '0;
        end
    end

endmodule

// File: rtl/tlb_checker.sv
// Module: tlb_checker
// Temporal checks on the translation cache, attached by bind.
// Assumes: it sees the top module's slot valid and lookup match vectors.
module tlb_checker #(
    parameter int ENTRIES = 16,
    parameter int PFN_W   = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               rf_valid,
    input logic               inv_all,
    input logic               inv_asid_en,
    input logic [ENTRIES-1:0] entry_valid,
    input logic [ENTRIES-1:0] lk_match,
    input logic               rs_valid,
    input logic               rs_hit,
    input logic               rs_miss,
    input logic               rs_fault,
    input logic [PFN_W-1:0]   rs_pfn
);

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> $onehot({rs_hit, rs_miss, rs_fault})); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_miss && !rs_fault && rs_pfn == '0)); // R2

    AST_PFN_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_hit |-> rs_pfn == '0); // R5

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid); // R2

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> entry_valid == '0); // R9

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R8

    AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && !inv_all && !inv_asid_en) |=> entry_valid != '0); // R6

endmodule

bind asid_tlb tlb_checker #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .rf_valid   (rf_valid),
    .inv_all    (inv_all),
    .inv_asid_en(inv_asid_en),
    .entry_valid(entry_valid),
    .lk_match   (lk_match),
    .rs_valid   (rs_valid),
    .rs_hit     (rs_hit),
    .rs_miss    (rs_miss),
    .rs_fault   (rs_fault),
    .rs_pfn     (rs_pfn)
);

// File: tb/asid_tlb_test.sv
// Bench: behavioural reference model stepped on every posedge, compared
// with the registered outputs on every falling edge.
module asid_tlb_test;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 0;
    logic [19:0] lk_vpn = 0;
    logic [7:0]  lk_asid = 0;
    logic [1:0]  lk_acc = 0;
    logic        rf_valid = 0;
    logic [19:0] rf_vpn = 0;
    logic [7:0]  rf_asid = 0;
    logic [19:0] rf_pfn = 0;
    logic [2:0]  rf_perm = 0;
    logic        rf_global = 0;
    logic        inv_all = 0;
    logic        inv_asid_en = 0;
    logic [7:0]  inv_asid = 0;
    logic        rs_valid, rs_hit, rs_miss, rs_fault;
    logic [19:0] rs_pfn;

    int    checks = 0;
    int    failures = 0;
    string cur_tag = "R1";
    bit    armed = 0;

    asid_tlb uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_acc(lk_acc),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn),
        .rf_perm(rf_perm), .rf_global(rf_global),
        .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
        .rs_fault(rs_fault), .rs_pfn(rs_pfn)
    );

    always #2 clk = ~clk;

    // Reference model state.
    bit        m_v[N];
    bit        m_g[N];
    int        m_asid[N];
    int        m_vpn[N];
    int        m_pfn[N];
    int        m_perm[N];
    bit [15:0] m_rand;
    bit        e_valid, e_hit, e_miss, e_fault;
    int        e_pfn;

    function automatic int needed(int acc);
        if (acc == 0) return 1;
        if (acc == 1) return 2;
        if (acc == 2) return 4;
        return 3;
    endfunction

    // Model step: result from pre-edge contents, then this edge's updates.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_v[i]) m_v[i] = 0;
            m_rand = 16'hACE1;
            e_valid = 0; e_hit = 0; e_miss = 0; e_fault = 0; e_pfn = 0;
        end else begin
            int hit_i;
            int slot;
            hit_i = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == int'(lk_vpn) &&
                    (m_g[i] || m_asid[i] == int'(lk_asid))) hit_i = i;
            e_valid = lk_valid;
            e_hit = 0; e_miss = 0; e_fault = 0; e_pfn = 0;
            if (lk_valid) begin
                if (hit_i < 0) e_miss = 1;
                else if ((m_perm[hit_i] & needed(int'(lk_acc))) == needed(int'(lk_acc))) begin
                    e_hit = 1; e_pfn = m_pfn[hit_i];
                end else e_fault = 1;
            end
            if (inv_all) begin
                foreach (m_v[i]) m_v[i] = 0;
            end else if (inv_asid_en) begin
                foreach (m_v[i]) if (!m_g[i] && m_asid[i] == int'(inv_asid)) m_v[i] = 0;
            end else if (rf_valid) begin
                slot = -1;
                for (int i = N - 1; i >= 0; i--)
                    if (m_v[i] && m_vpn[i] == int'(rf_vpn) &&
                        (m_g[i] || rf_global || m_asid[i] == int'(rf_asid))) slot = i;
                for (int i = 0; i < N; i++)
                    if (m_v[i] && m_vpn[i] == int'(rf_vpn) &&
                        (m_g[i] || rf_global || m_asid[i] == int'(rf_asid))) m_v[i] = 0;
                if (slot < 0)
                    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) slot = int'(m_rand[3:0]);
                m_v[slot] = 1; m_g[slot] = rf_global; m_asid[slot] = int'(rf_asid);
                m_vpn[slot] = int'(rf_vpn); m_pfn[slot] = int'(rf_pfn);
                m_perm[slot] = int'(rf_perm);
            end
            m_rand = {m_rand[14:0], m_rand[15] ^ m_rand[13] ^ m_rand[12] ^ m_rand[10]};
        end
        armed = 1;
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            chk("rs_valid", int'(rs_valid), int'(e_valid));
            chk("rs_hit",   int'(rs_hit),   int'(e_hit));
            chk("rs_miss",  int'(rs_miss),  int'(e_miss));
            chk("rs_fault", int'(rs_fault), int'(e_fault));
            chk("rs_pfn",   int'(rs_pfn),   e_pfn);
        end
    end

    task automatic clr();
        lk_valid = 0; rf_valid = 0; inv_all = 0; inv_asid_en = 0;
    endtask

    task automatic look(input int vpn, input int asid, input int acc);
        clr(); lk_valid = 1; lk_vpn = 20'(vpn); lk_asid = 8'(asid); lk_acc = 2'(acc);
        @(negedge clk);
    endtask

    task automatic fill(input int vpn, input int asid, input int pfn,
                        input int perm, input bit g);
        clr(); rf_valid = 1; rf_vpn = 20'(vpn); rf_asid = 8'(asid);
        rf_pfn = 20'(pfn); rf_perm = 3'(perm); rf_global = g;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        clr();
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("reset rs_valid", int'(rs_valid), 0);
        chk("reset rs_pfn", int'(rs_pfn), 0);
        look('h5, 1, 0);
        look('h0, 0, 0);
        idle(1);

        cur_tag = "R6";
        fill('h100, 1, 'hA00, 7, 0);
        fill('h101, 1, 'hA01, 1, 0);
        fill('h200, 2, 'hB00, 3, 0);
        fill('h300, 9, 'hC00, 5, 1);
        look('h101, 1, 0);

        cur_tag = "R3";
        look('h100, 1, 0);
        look('h300, 4, 0);
        look('h200, 2, 0);

        cur_tag = "R5";
        look('h100, 2, 0);
        look('h999, 1, 0);

        cur_tag = "R4";
        look('h101, 1, 1);
        look('h101, 1, 2);
        look('h200, 2, 3);
        look('h200, 2, 2);
        look('h300, 3, 1);
        look('h300, 3, 2);
        look('h100, 1, 3);

        cur_tag = "R8";
        fill('h100, 1, 'hAAA, 7, 0);
        look('h100, 1, 0);
        fill('h200, 0, 'hDDD, 7, 1);
        look('h200, 7, 0);
        look('h200, 2, 1);

        cur_tag = "R11";
        clr(); rf_valid = 1; rf_vpn = 'h400; rf_asid = 1; rf_pfn = 'h444;
        rf_perm = 7; rf_global = 0; lk_valid = 1; lk_vpn = 'h400; lk_asid = 1; lk_acc = 0;
        @(negedge clk);
        look('h400, 1, 0);
        clr(); rf_valid = 1; rf_vpn = 'h500; rf_asid = 1; rf_pfn = 'h555;
        rf_perm = 7; inv_asid_en = 1; inv_asid = 3;
        @(negedge clk);
        look('h500, 1, 0);
        clr(); inv_asid_en = 1; inv_asid = 1; lk_valid = 1; lk_vpn = 'h100; lk_asid = 1;
        @(negedge clk);

        cur_tag = "R10";
        look('h100, 1, 0);
        look('h400, 1, 0);
        look('h300, 1, 0);
        look('h200, 5, 0);
        fill('h600, 2, 'h666, 7, 0);
        clr(); inv_asid_en = 1; inv_asid = 1;
        @(negedge clk);
        look('h600, 2, 0);

        cur_tag = "R7";
        for (int k = 0; k < 40; k++) fill('h1000 + k, k % 3, 'h2000 + k, 7, 0);
        for (int k = 0; k < 40; k++) look('h1000 + k, k % 3, 0);

        cur_tag = "R9";
        clr(); inv_all = 1; rf_valid = 1; rf_vpn = 'h777; rf_pfn = 'h777; rf_perm = 7;
        @(negedge clk);
        look('h300, 0, 0);
        look('h777, 0, 0);
        look('h1027, 0, 0);

        cur_tag = "R2";
        clr(); lk_vpn = 'h300; lk_asid = 0;
        idle(3);

        cur_tag = "R7";
        for (int c = 0; c < 4000; c++) begin
            int r;
            clr();
            r = $urandom_range(0, 99);
            lk_valid = ($urandom_range(0, 1) == 1);
            lk_vpn = 20'($urandom_range(0, 23));
            lk_asid = 8'($urandom_range(0, 3));
            lk_acc = 2'($urandom_range(0, 3));
            if (r < 40) begin
                rf_valid = 1; rf_vpn = 20'($urandom_range(0, 23));
                rf_asid = 8'($urandom_range(0, 3)); rf_pfn = 20'($urandom);
                rf_perm = 3'($urandom_range(0, 7)); rf_global = ($urandom_range(0, 9) == 0);
            end else if (r < 42) begin
                inv_asid_en = 1; inv_asid = 8'($urandom_range(0, 3));
            end else if (r == 42) begin
                inv_all = 1;
            end
            @(negedge clk);
        end
        idle(2);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule